// File: doc/BRIEF.md
# Address-Decoding Request Router

This block is the request-side switching stage that sits behind one master of a small lite-style interconnect. It takes a single address-phase request stream (address plus transaction ID). It finds the target port whose inclusive byte window contains the address, checks that this master is allowed to reach that target, and forwards the request to that one port. When the target is configured to do so, the address is rebased to an offset relative to the window start. A request that finds no permitted target is not forwarded. The router accepts it itself and answers with a decode-error response.

On the return side, completions from the shared response network come in on one stream. The router passes to its master only the completions whose ID carries all bits of the configured ID mask. Others are left untouched (not accepted). A watchdog limits how long a forwarded request may wait for its target. When it expires, the request is dropped and answered with an error.

All streams use valid/ready with these rules for back-pressure. A source holds valid and its payload until the cycle in which ready is high. The router holds one request at a time, so `req_ready` falls after an accept and rises again once the request has left. An internally generated error response has priority over completions. It holds `rsp_valid` and its payload until `rsp_ready`, and while it is pending no new request is accepted.

Top module: `addr_route_stage`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `req_ready` is 1, all `fwd_valid` bits are 0, `timeout_pulse` is 0, and `rsp_valid` is 0 while no completion is offered.
- R2: Target k is a candidate when `WIN_START[k] <= req_addr <= WIN_END[k]`, both bounds inclusive. An address equal to either bound decodes to that target. An address one past a bound does not.
- R3: A target whose bit in `ROUTE_MASK` (bit k for target k) is 0 is never selected. Its `fwd_valid` bit never rises.
- R4: Among the candidates that are permitted, the lowest-numbered one receives the request. This applies to overlapping windows, and also when a lower window that matches is not permitted.
- R5: `fwd_id` equals the accepted request ID. `fwd_addr` equals `req_addr - WIN_START[k]` when `KEEP_BASE[k]` is 0, and equals `req_addr` unchanged when it is 1.
- R6: A request with no permitted candidate is accepted and never forwarded. The cycle after acceptance, `rsp_valid` is 1 with `rsp_resp` = 2'b11 and `rsp_id` equal to the request ID.
- R7: The cycle after a request with a permitted target is accepted, exactly the selected `fwd_valid` bit is 1. It stays 1, with `fwd_addr`/`fwd_id` stable, until a cycle with that target's `fwd_ready` high. After that cycle it is 0.
- R8: An offered completion matches when `(cpl_id & ID_MASK) == ID_MASK`. A matching completion appears on `rsp_*` with the same ID and response code, and `cpl_ready` follows `rsp_ready`. A non-matching completion keeps `cpl_ready` and `rsp_valid` at 0.
- R9: If a forwarded request is not accepted within `TIMEOUT_LIMIT` cycles, the router does the following. Its `fwd_valid` drops after exactly `TIMEOUT_LIMIT` cycles high. `timeout_pulse` is 1 for one cycle. An error response with `rsp_resp` = 2'b10 and the request ID is raised.
- R10: While an internal error response waits for `rsp_ready`, its ID and code hold steady, it masks any offered completion (`cpl_ready` 0), and `req_ready` is 0.
- R11: A synchronous reset during a forward or while an error response is pending drops `fwd_valid`, removes the pending response and restores `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered by the master |
| req_ready | output | 1 | Router can take a request |
| req_addr | input | ADDR_W | Request byte address |
| req_id | input | ID_W | Request transaction ID |
| fwd_valid | output | NUM_TGT | Per-target request valid, at most one set |
| fwd_ready | input | NUM_TGT | Per-target request ready |
| fwd_addr | output | ADDR_W | Forwarded (possibly rebased) address |
| fwd_id | output | ID_W | Forwarded transaction ID |
| cpl_valid | input | 1 | Completion offered by the response network |
| cpl_ready | output | 1 | Completion taken by this router |
| cpl_id | input | ID_W | Completion transaction ID |
| cpl_resp | input | 2 | Completion response code |
| rsp_valid | output | 1 | Response to the master valid |
| rsp_ready | input | 1 | Master accepts the response |
| rsp_id | output | ID_W | Response transaction ID |
| rsp_resp | output | 2 | Response code |
| timeout_pulse | output | 1 | One-cycle flag on watchdog expiry |

## Verification
The bench builds a memory map with two overlapping windows, one window that is not permitted, a window that overlaps the non-permitted one, a base-keeping target and a gap above the map. It drives requests exactly on and one past every bound. An off-by-one comparison would send those to a neighbour or to decode error. Dropping the permission mask would make the forbidden target's valid rise. A priority encoder running the wrong way would give overlapping addresses to the higher target. Random addresses and random target stall lengths are checked against a decode function in the bench. Directed cases cover the watchdog and the error path. A watchdog counting one too many or too few cycles shows in the measured valid length. If an error response does not take priority or hold steady, a completion would leak through or `req_ready` would rise early. Completion IDs with and without the mask bits check that foreign completions are never taken.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FWD  = 1'b1
  } route_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;

endpackage

// File: rtl/addr_route_decode.sv
module addr_route_decode #(
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 2,
  parameter logic [NUM_TGT*ADDR_W-1:0] WIN_START = '0,
  parameter logic [NUM_TGT*ADDR_W-1:0] WIN_END   = '1,
  parameter logic [NUM_TGT-1:0] ROUTE_MASK = '1,
  parameter logic [NUM_TGT-1:0] KEEP_BASE  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] out_addr
);

  logic [NUM_TGT-1:0] win_hit;
  logic [NUM_TGT-1:0] cand;

  // inclusive window compare, one per target
  for (genvar k = 0; k < NUM_TGT; k++) begin : g_win
    assign win_hit[k] = (addr >= WIN_START[k*ADDR_W +: ADDR_W]) &&
                        (addr <= WIN_END[k*ADDR_W +: ADDR_W]);
  end

  assign cand = win_hit & ROUTE_MASK;
  assign hit  = |cand;

  // lowest permitted candidate wins: scan downwards so the last write is the lowest
  always_comb begin
    idx      = '0;
    out_addr = addr;
    for (int k = NUM_TGT - 1; k >= 0; k--) begin
      if (cand[k]) begin
        idx      = IDX_W'(k);
        out_addr = KEEP_BASE[k] ? addr : (addr - WIN_START[k*ADDR_W +: ADDR_W]);
      end
    end
  end

endmodule

// File: rtl/addr_route_watchdog.sv
module addr_route_watchdog #(
  parameter int TIMEOUT_LIMIT = 10000,
  parameter bit TIMEOUT_EN    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  output logic expire
);

  localparam int CNT_W = (TIMEOUT_LIMIT > 2) ? $clog2(TIMEOUT_LIMIT) : 1;

  if (TIMEOUT_EN) begin : g_on
    logic [CNT_W-1:0] cnt_q;

    assign expire = waiting && (cnt_q == CNT_W'(TIMEOUT_LIMIT - 1));

    always_ff @(posedge clk) begin
      if (!rst_n || !waiting || expire) cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(TIMEOUT_LIMIT - 1));

    // R9
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !waiting |=> cnt_q == '0);
  end else begin : g_off
    assign expire = 1'b0;
  end

endmodule

// File: rtl/addr_route_rsp_mux.sv
module addr_route_rsp_mux
  import addr_route_pkg::*;
#(
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] ID_MASK = 8'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_set,
  input  logic [1:0]      err_code,
  input  logic [ID_W-1:0] err_id,
  output logic            err_busy,
  input  logic            cpl_valid,
  output logic            cpl_ready,
  input  logic [ID_W-1:0] cpl_id,
  input  logic [1:0]      cpl_resp,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [ID_W-1:0] rsp_id,
  output logic [1:0]      rsp_resp
);

  logic            err_q;
  logic [ID_W-1:0] err_id_q;
  logic [1:0]      err_code_q;
  logic            cpl_mine;

  assign cpl_mine = (cpl_id & ID_MASK) == ID_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      err_id_q   <= '0;
      err_code_q <= RESP_OKAY;
    end else if (err_set) begin
      err_q      <= 1'b1;
      err_id_q   <= err_id;
      err_code_q <= err_code;
    end else if (rsp_ready) begin
      err_q      <= 1'b0;
    end
  end

  assign err_busy  = err_q;
  assign rsp_valid = err_q || (cpl_valid && cpl_mine);
  assign rsp_id    = err_q ? err_id_q   : cpl_id;
  assign rsp_resp  = err_q ? err_code_q : cpl_resp;
  assign cpl_ready = !err_q && cpl_mine && rsp_ready;

  // R8
  foreign_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_ready |-> (cpl_id & ID_MASK) == ID_MASK);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !rsp_ready |=> rsp_valid && $stable(rsp_id) && $stable(rsp_resp));

endmodule

// File: rtl/addr_route_stage.sv
module addr_route_stage
  import addr_route_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 16,
  parameter int ID_W    = 8,
  parameter logic [ID_W-1:0] ID_MASK = 8'h10,
  parameter logic [NUM_TGT*ADDR_W-1:0] WIN_START =
    {16'd12288, 16'd8192, 16'd4096, 16'd0},
  parameter logic [NUM_TGT*ADDR_W-1:0] WIN_END =
    {16'd16383, 16'd12287, 16'd8191, 16'd4095},
  parameter logic [NUM_TGT-1:0] ROUTE_MASK = '1,
  parameter logic [NUM_TGT-1:0] KEEP_BASE  = '0,
  parameter int TIMEOUT_LIMIT = 10000,
  parameter bit TIMEOUT_EN    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [ID_W-1:0]    req_id,
  output logic [NUM_TGT-1:0] fwd_valid,
  input  logic [NUM_TGT-1:0] fwd_ready,
  output logic [ADDR_W-1:0]  fwd_addr,
  output logic [ID_W-1:0]    fwd_id,
  input  logic               cpl_valid,
  output logic               cpl_ready,
  input  logic [ID_W-1:0]    cpl_id,
  input  logic [1:0]         cpl_resp,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ID_W-1:0]    rsp_id,
  output logic [1:0]         rsp_resp,
  output logic               timeout_pulse
);

  localparam int IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

  route_state_e      state_q;
  logic [IDX_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   id_q;
  logic              tmo_q;

  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic [ADDR_W-1:0] dec_addr;
  logic              err_busy;
  logic              accept;
  logic              sel_ready;
  logic              waiting;
  logic              expire;
  logic              err_set;
  logic [1:0]        err_code;
  logic [ID_W-1:0]   err_id;

  addr_route_decode #(
    .NUM_TGT    (NUM_TGT),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .WIN_START  (WIN_START),
    .WIN_END    (WIN_END),
    .ROUTE_MASK (ROUTE_MASK),
    .KEEP_BASE  (KEEP_BASE)
  ) u_decode (
    .addr     (req_addr),
    .hit      (dec_hit),
    .idx      (dec_idx),
    .out_addr (dec_addr)
  );

  assign req_ready = (state_q == ST_IDLE) && !err_busy;
  assign accept    = req_valid && req_ready;
  assign sel_ready = fwd_ready[sel_q];
  assign waiting   = (state_q == ST_FWD) && !sel_ready;

  addr_route_watchdog #(
    .TIMEOUT_LIMIT (TIMEOUT_LIMIT),
    .TIMEOUT_EN    (TIMEOUT_EN)
  ) u_watchdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .waiting (waiting),
    .expire  (expire)
  );

  // the two error sources are exclusive: misses only in idle, expiry only while forwarding
  assign err_set  = (accept && !dec_hit) || expire;
  assign err_code = expire ? RESP_SLVERR : RESP_DECERR;
  assign err_id   = expire ? id_q : req_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      addr_q  <= '0;
      id_q    <= '0;
      tmo_q   <= 1'b0;
    end else begin
      tmo_q <= expire;
      case (state_q)
        ST_IDLE: if (accept && dec_hit) begin
          state_q <= ST_FWD;
          sel_q   <= dec_idx;
          addr_q  <= dec_addr;
          id_q    <= req_id;
        end
        ST_FWD: if (sel_ready || expire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_fwd
    assign fwd_valid[k] = (state_q == ST_FWD) && (sel_q == IDX_W'(k));
  end

  assign fwd_addr      = addr_q;
  assign fwd_id        = id_q;
  assign timeout_pulse = tmo_q;

  addr_route_rsp_mux #(
    .ID_W    (ID_W),
    .ID_MASK (ID_MASK)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_set   (err_set),
    .err_code  (err_code),
    .err_id    (err_id),
    .err_busy  (err_busy),
    .cpl_valid (cpl_valid),
    .cpl_ready (cpl_ready),
    .cpl_id    (cpl_id),
    .cpl_resp  (cpl_resp),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_id    (rsp_id),
    .rsp_resp  (rsp_resp)
  );

  // R3
  route_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid & ~ROUTE_MASK) == '0);

  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_valid));

  // R7
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fwd_valid & ~fwd_ready)) && !expire |=>
      fwd_valid == $past(fwd_valid) && $stable(fwd_addr) && $stable(fwd_id));

  // R6
  miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !dec_hit |=>
      fwd_valid == '0 && rsp_valid && rsp_resp == RESP_DECERR);

  // R9
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> fwd_valid == '0 && !timeout_pulse && req_ready);

endmodule

// File: tb/addr_route_stage_bench.sv
module addr_route_stage_bench;

  localparam int NT = 4;
  localparam int AW = 16;
  localparam int IW = 8;
  localparam logic [IW-1:0] MASK = 8'h10;
  localparam logic [NT*AW-1:0] STARTS = {16'h2800, 16'h2000, 16'h0800, 16'h0000};
  localparam logic [NT*AW-1:0] ENDS   = {16'h3FFF, 16'h2FFF, 16'h1FFF, 16'h0FFF};
  localparam logic [NT-1:0] ROUTE = 4'b1011;
  localparam logic [NT-1:0] KEEP  = 4'b0010;
  localparam int LIMIT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [IW-1:0] req_id = '0;
  logic [NT-1:0] fwd_valid;
  logic [NT-1:0] fwd_ready = '0;
  logic [AW-1:0] fwd_addr;
  logic [IW-1:0] fwd_id;
  logic cpl_valid = 1'b0;
  logic cpl_ready;
  logic [IW-1:0] cpl_id = '0;
  logic [1:0] cpl_resp = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [IW-1:0] rsp_id;
  logic [1:0] rsp_resp;
  logic timeout_pulse;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  addr_route_stage #(
    .NUM_TGT(NT), .ADDR_W(AW), .ID_W(IW), .ID_MASK(MASK),
    .WIN_START(STARTS), .WIN_END(ENDS), .ROUTE_MASK(ROUTE), .KEEP_BASE(KEEP),
    .TIMEOUT_LIMIT(LIMIT), .TIMEOUT_EN(1'b1)
  ) u_addr_route_stage (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_id(req_id),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_id(fwd_id),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_id(cpl_id), .cpl_resp(cpl_resp),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_resp(rsp_resp),
    .timeout_pulse(timeout_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int ref_target(input logic [AW-1:0] a);
    for (int k = 0; k < NT; k++)
      if (ROUTE[k] && a >= STARTS[k*AW +: AW] && a <= ENDS[k*AW +: AW]) return k;
    return -1;
  endfunction

  function automatic logic [AW-1:0] ref_addr(input logic [AW-1:0] a, input int k);
    return KEEP[k] ? a : a - STARTS[k*AW +: AW];
  endfunction

  // offer one request and return at the negedge after it was taken
  task automatic offer(input logic [AW-1:0] a, input logic [IW-1:0] id);
    req_addr  = a;
    req_id    = id;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain_rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  // full request with expected outcome checked; stall = cycles before ready
  task automatic run_req(input string req, input logic [AW-1:0] a,
                         input logic [IW-1:0] id, input int stall);
    int t;
    t = ref_target(a);
    offer(a, id);
    if (t < 0) begin
      check({req, " R6 no forward"}, 32'(fwd_valid), 32'h0);
      check({req, " R6 decerr valid"}, 32'(rsp_valid), 32'h1);
      check({req, " R6 decerr code"}, 32'(rsp_resp), 32'h3);
      check({req, " R6 decerr id"}, 32'(rsp_id), 32'(id));
      check({req, " R10 busy"}, 32'(req_ready), 32'h0);
      drain_rsp();
      check({req, " R6 rsp gone"}, 32'(rsp_valid), 32'h0);
    end else begin
      check({req, " R2/R4 target"}, 32'(fwd_valid), 32'(1 << t));
      check({req, " R5 addr"}, 32'(fwd_addr), 32'(ref_addr(a, t)));
      check({req, " R5 id"}, 32'(fwd_id), 32'(id));
      for (int s = 0; s < stall; s++) @(negedge clk);
      check({req, " R7 held"}, 32'(fwd_valid), 32'(1 << t));
      check({req, " R7 addr stable"}, 32'(fwd_addr), 32'(ref_addr(a, t)));
      fwd_ready[t] = 1'b1;
      @(negedge clk);
      fwd_ready = '0;
      check({req, " R7 released"}, 32'(fwd_valid), 32'h0);
      check({req, " R7 ready back"}, 32'(req_ready), 32'h1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_errors++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [IW-1:0] rid;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 req_ready", 32'(req_ready), 32'h1);
    check("R1 fwd_valid", 32'(fwd_valid), 32'h0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check("R1 timeout", 32'(timeout_pulse), 32'h0);

    // R2 bounds, R3 forbidden target, R4 overlap priority, R5 rebasing
    run_req("R2 t0 low", 16'h0000, 8'h01, 0);
    run_req("R2 t0 high", 16'h0FFF, 8'h02, 1);
    run_req("R4 overlap t0", 16'h0800, 8'h03, 0);
    run_req("R5 keep base t1", 16'h1000, 8'h04, 2);
    run_req("R2 t1 high", 16'h1FFF, 8'h05, 0);
    run_req("R3 forbidden t2", 16'h2000, 8'h06, 0);
    run_req("R3 forbidden t2 top", 16'h27FF, 8'h07, 0);
    run_req("R4 skip forbidden to t3", 16'h2800, 8'h08, 1);
    run_req("R5 t3 high", 16'h3FFF, 8'h09, 0);
    run_req("R6 above map", 16'h4000, 8'h0A, 0);

    // random requests with random stall lengths
    for (int i = 0; i < 80; i++)
      run_req("R2 random", 16'($urandom_range(0, 16'h47FF)), 8'($urandom), $urandom_range(0, 5));

    // R9 watchdog expiry
    offer(16'h0100, 8'h55);
    n = 0;
    while (fwd_valid[0] && n < 200) begin
      n++;
      @(negedge clk);
    end
    check("R9 valid length", 32'(n), 32'(LIMIT));
    check("R9 pulse", 32'(timeout_pulse), 32'h1);
    check("R9 err valid", 32'(rsp_valid), 32'h1);
    check("R9 err code", 32'(rsp_resp), 32'h2);
    check("R9 err id", 32'(rsp_id), 32'h55);
    // R10 pending error blocks requests and masks a matching completion
    cpl_valid = 1'b1; cpl_id = 8'h11; cpl_resp = 2'b01;
    @(negedge clk);
    check("R9 pulse single", 32'(timeout_pulse), 32'h0);
    check("R10 req blocked", 32'(req_ready), 32'h0);
    check("R10 code held", 32'(rsp_resp), 32'h2);
    check("R10 id held", 32'(rsp_id), 32'h55);
    rsp_ready = 1'b1;
    #1;
    check("R10 cpl masked", 32'(cpl_ready), 32'h0);
    @(negedge clk);
    check("R10 cpl after err", 32'(rsp_id), 32'h11);
    check("R10 cpl taken", 32'(cpl_ready), 32'h1);
    check("R10 ready back", 32'(req_ready), 32'h1);
    rsp_ready = 1'b0;
    cpl_valid = 1'b0;

    // R8 completion filter, directed then random
    @(negedge clk);
    cpl_valid = 1'b1; cpl_id = 8'h23; cpl_resp = 2'b00; rsp_ready = 1'b1;
    #1;
    check("R8 foreign rsp_valid", 32'(rsp_valid), 32'h0);
    check("R8 foreign cpl_ready", 32'(cpl_ready), 32'h0);
    cpl_id = 8'h13; cpl_resp = 2'b01; rsp_ready = 1'b0;
    #1;
    check("R8 mine valid", 32'(rsp_valid), 32'h1);
    check("R8 backpressure", 32'(cpl_ready), 32'h0);
    check("R8 mine resp", 32'(rsp_resp), 32'h1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      rid = 8'($urandom);
      cpl_id = rid; cpl_resp = 2'($urandom); rsp_ready = 1'($urandom);
      #1;
      check("R8 random valid", 32'(rsp_valid), 32'((rid & MASK) == MASK));
      check("R8 random ready", 32'(cpl_ready), 32'(((rid & MASK) == MASK) && rsp_ready));
      if ((rid & MASK) == MASK) check("R8 random id", 32'(rsp_id), 32'(rid));
    end
    @(negedge clk);
    cpl_valid = 1'b0; rsp_ready = 1'b0;

    // R11 reset during forward and during pending error
    offer(16'h3000, 8'h66);
    check("R11 forwarding", 32'(fwd_valid), 32'h8);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R11 fwd cleared", 32'(fwd_valid), 32'h0);
    check("R11 ready", 32'(req_ready), 32'h1);
    offer(16'h2100, 8'h77);
    check("R11 err pending", 32'(rsp_valid), 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R11 err cleared", 32'(rsp_valid), 32'h0);
    check("R11 ready after err", 32'(req_ready), 32'h1);
    run_req("R11 after reset", 16'h1800, 8'h78, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule